// File: doc/BRIEF.md
# UART Interrupt Prioritiser

This block decides which interrupt a 16550-style UART with FIFOs reports and whether its interrupt request line is asserted. It keeps a pending flag for each of five sources: receiver line errors, received data, receive character timeout, transmit data request and modem-line changes. It then encodes the highest-priority pending source as a 4-bit identifier. The serial shifters, FIFO storage and baud generator are outside the block. They feed it fill levels, error pulses, a bit-time tick and a start-bit strobe. The register file feeds it one-cycle access strobes.

The block contains the receive idle timer that produces the character-timeout source. It also switches between the two operating modes. In FIFO mode, the received-data and transmit conditions are taken from FIFO fill levels. In single-buffer mode, they are taken from the holding-register state.

Top module: `uart_irq_prio`

## Requirements
- R1: `irq_id` is 4'b0001 with `irq` low when nothing is pending, including during and right after reset. Whenever any source is pending, `irq` is high.
- R2: The identifiers are: line error 4'b0110, received data 4'b0100, timeout 4'b1100, transmit request 4'b0010, modem change 4'b0000. Priority runs line error, then received data, then timeout, then transmit request, then modem change.
- R3: A pulse on any of `err_overrun`, `err_parity`, `err_framing` or `err_break` sets the line-error source at the next edge. Only an `lsr_rd` pulse clears it. When both arrive in the same cycle, the source stays set.
- R4: In single-buffer mode (`fifo_mode`=0), `rx_push` sets the received-data source and `rbr_rd` clears it.
- R5: In FIFO mode, the received-data source is registered from `rx_level >= rx_trigger`. A cycle in which `fcr_wr` and `fcr_rx_reset` are both high forces it clear at the next edge. An `fcr_wr` with `fcr_rx_reset` low has no effect on it.
- R6: In FIFO mode only, the timeout source is raised one edge after the idle counter reaches BITS_PER_CHAR*TIMEOUT_CHARS `bit_tick` pulses (40 by default), provided `rx_level` is nonzero. The idle counter restarts on `rx_push`, `rbr_rd`, `start_bit` or a receive-FIFO reset.
- R7: The timeout source is cleared by `rbr_rd`, by `start_bit`, or by `fcr_wr` with `fcr_rx_reset` high.
- R8: The transmit request is set when its condition becomes true: `tx_level` == 0 in single-buffer mode, or `tx_level` <= FIFO_DEPTH/2 in FIFO mode. It stays low while that condition merely persists after being cleared, and it drops if the condition goes false.
- R9: `thr_wr` clears the transmit request. `iir_rd` also clears it at the next edge, but only when `irq_id` shows 4'b0010 in the read cycle. An `iir_rd` while another source is reported leaves it pending.
- R10: A pulse on any of `msc_cts`, `msc_dsr`, `msc_ri` or `msc_dcd` sets the modem-change source. Only `msr_rd` clears it. When both arrive in the same cycle, the source stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_mode | input | 1 | 1 = FIFO mode, 0 = single-buffer mode |
| err_overrun | input | 1 | Overrun detected pulse |
| err_parity | input | 1 | Parity error pulse |
| err_framing | input | 1 | Framing error pulse |
| err_break | input | 1 | Break detected pulse |
| rx_level | input | LVL_W | Receive FIFO fill level |
| rx_trigger | input | LVL_W | Receive FIFO trigger threshold |
| rx_push | input | 1 | Character written into the receive buffer |
| start_bit | input | 1 | New start bit detected |
| bit_tick | input | 1 | One pulse per serial bit time |
| tx_level | input | LVL_W | Transmit FIFO fill level |
| msc_cts | input | 1 | Clear-to-send changed |
| msc_dsr | input | 1 | Data-set-ready changed |
| msc_ri | input | 1 | Ring indicator changed |
| msc_dcd | input | 1 | Carrier detect changed |
| iir_rd | input | 1 | Interrupt identification read strobe |
| lsr_rd | input | 1 | Line status read strobe |
| msr_rd | input | 1 | Modem status read strobe |
| rbr_rd | input | 1 | Receive buffer / FIFO read strobe |
| thr_wr | input | 1 | Transmit holding register / FIFO write strobe |
| fcr_wr | input | 1 | FIFO control write strobe |
| fcr_rx_reset | input | 1 | Receive-FIFO reset bit of that write |
| irq_id | output | 4 | Encoded pending interrupt |
| irq | output | 1 | Interrupt request |

## Verification
The timeout source is the hardest to bring about from the ports. It needs FIFO mode, a nonempty receive level below the trigger, and forty tick pulses with no push, read or start bit in between. It then needs exactly one clearing strobe. The stimulus holds those inputs quiet while it counts ticks. It checks that the identifier is still clear after the fortieth tick and appears one edge later. It then rebuilds the same window before each of the three clearing strobes, and once with received data also pending, so that priority is visible. A behavioural model compares the identifier on every clock throughout.

// File: rtl/uart_irq_prio.sv
module uart_irq_prio #(
  parameter int FIFO_DEPTH    = 16,
  parameter int BITS_PER_CHAR = 10,
  parameter int TIMEOUT_CHARS = 4,
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_mode,
  input  logic             err_overrun,
  input  logic             err_parity,
  input  logic             err_framing,
  input  logic             err_break,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] rx_trigger,
  input  logic             rx_push,
  input  logic             start_bit,
  input  logic             bit_tick,
  input  logic [LVL_W-1:0] tx_level,
  input  logic             msc_cts,
  input  logic             msc_dsr,
  input  logic             msc_ri,
  input  logic             msc_dcd,
  input  logic             iir_rd,
  input  logic             lsr_rd,
  input  logic             msr_rd,
  input  logic             rbr_rd,
  input  logic             thr_wr,
  input  logic             fcr_wr,
  input  logic             fcr_rx_reset,
  output logic [3:0]       irq_id,
  output logic             irq
);

  localparam int TO_LIMIT = BITS_PER_CHAR * TIMEOUT_CHARS;
  localparam int CNT_W    = $clog2(TO_LIMIT + 1);
  localparam int HALF     = FIFO_DEPTH / 2;

  localparam logic [3:0] ID_NONE = 4'b0001;
  localparam logic [3:0] ID_LINE = 4'b0110;
  localparam logic [3:0] ID_RXD  = 4'b0100;
  localparam logic [3:0] ID_TOUT = 4'b1100;
  localparam logic [3:0] ID_TXR  = 4'b0010;
  localparam logic [3:0] ID_MDM  = 4'b0000;

  logic             line_q, rxd_q, tout_q, txr_q, mdm_q, txc_d;
  logic [CNT_W-1:0] idle_cnt;

  wire rx_flush   = fcr_wr & fcr_rx_reset;
  wire any_err    = err_overrun | err_parity | err_framing | err_break;
  wire any_msc    = msc_cts | msc_dsr | msc_ri | msc_dcd;
  wire txc        = fifo_mode ? (tx_level <= LVL_W'(HALF)) : (tx_level == '0);
  wire rx_hit     = rx_level >= rx_trigger;
  wire rx_some    = rx_level != '0;
  wire idle_rst   = rx_push | rbr_rd | start_bit | rx_flush | ~fifo_mode;
  wire tout_clr   = rbr_rd | start_bit | rx_flush;
  wire idle_full  = idle_cnt == CNT_W'(TO_LIMIT);
  wire txr_clr    = thr_wr | (iir_rd & (irq_id == ID_TXR));

  always_comb begin
    if (line_q)      irq_id = ID_LINE;
    else if (rxd_q)  irq_id = ID_RXD;
    else if (tout_q) irq_id = ID_TOUT;
    else if (txr_q)  irq_id = ID_TXR;
    else if (mdm_q)  irq_id = ID_MDM;
    else             irq_id = ID_NONE;
  end

  assign irq = irq_id != ID_NONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q   <= 1'b0;
      rxd_q    <= 1'b0;
      tout_q   <= 1'b0;
      txr_q    <= 1'b0;
      mdm_q    <= 1'b0;
      txc_d    <= 1'b0;
      idle_cnt <= '0;
    end else begin
      line_q <= any_err | (line_q & ~lsr_rd);
      mdm_q  <= any_msc | (mdm_q & ~msr_rd);

      if (fifo_mode)    rxd_q <= ~rx_flush & rx_hit;
      else if (rx_push) rxd_q <= 1'b1;
      else if (rbr_rd)  rxd_q <= 1'b0;

      if (idle_rst)                    idle_cnt <= '0;
      else if (bit_tick && !idle_full) idle_cnt <= idle_cnt + 1'b1;

      tout_q <= fifo_mode & rx_some & ~tout_clr & (tout_q | idle_full);

      txc_d <= txc;
      if (txr_clr || !txc) txr_q <= 1'b0;
      else if (!txc_d)     txr_q <= 1'b1;
    end
  end

  a_r1_idle_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_q && !rxd_q && !tout_q && !txr_q && !mdm_q) |-> (irq_id == ID_NONE && !irq));

  a_r3_error_reports_line: assert property (@(posedge clk) disable iff (!rst_n)
    any_err |=> irq_id == ID_LINE);

  a_r3_line_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_id == ID_LINE && !lsr_rd) |=> irq_id == ID_LINE);

  a_r10_modem_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (mdm_q && !msr_rd) |=> mdm_q);

  a_r5_flush_drops_rxd: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_flush && fifo_mode) |=> irq_id != ID_RXD);

  a_r6_no_timeout_single: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_mode |=> !tout_q);

  a_r7_start_clears_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    start_bit |=> !tout_q);

  a_r9_iir_read_clears_tx: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_rd && irq_id == ID_TXR) |=> !txr_q);

endmodule

// File: tb/uart_irq_prio_bench.sv
module uart_irq_prio_bench;
  localparam int LW = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fifo_mode = 0, err_overrun = 0, err_parity = 0, err_framing = 0, err_break = 0;
  logic [LW-1:0] rx_level = '0, rx_trigger = 5'd1, tx_level = 5'd1;
  logic rx_push = 0, start_bit = 0, bit_tick = 0;
  logic msc_cts = 0, msc_dsr = 0, msc_ri = 0, msc_dcd = 0;
  logic iir_rd = 0, lsr_rd = 0, msr_rd = 0, rbr_rd = 0, thr_wr = 0, fcr_wr = 0, fcr_rx_reset = 0;
  logic [3:0] irq_id;
  logic irq;

  int checks = 0, errors = 0, cycles = 0;
  string phase = "R1";

  always #10 clk = ~clk;

  uart_irq_prio u_uart_irq_prio (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode),
    .err_overrun(err_overrun), .err_parity(err_parity), .err_framing(err_framing), .err_break(err_break),
    .rx_level(rx_level), .rx_trigger(rx_trigger), .rx_push(rx_push), .start_bit(start_bit),
    .bit_tick(bit_tick), .tx_level(tx_level),
    .msc_cts(msc_cts), .msc_dsr(msc_dsr), .msc_ri(msc_ri), .msc_dcd(msc_dcd),
    .iir_rd(iir_rd), .lsr_rd(lsr_rd), .msr_rd(msr_rd), .rbr_rd(rbr_rd), .thr_wr(thr_wr),
    .fcr_wr(fcr_wr), .fcr_rx_reset(fcr_rx_reset), .irq_id(irq_id), .irq(irq)
  );

  // behavioural reference
  bit m_line, m_rxd, m_tout, m_txr, m_mdm, m_txc_d;
  int m_idle;

  function automatic logic [3:0] ref_id();
    if (m_line) return 4'b0110;
    if (m_rxd)  return 4'b0100;
    if (m_tout) return 4'b1100;
    if (m_txr)  return 4'b0010;
    if (m_mdm)  return 4'b0000;
    return 4'b0001;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_line <= 0; m_rxd <= 0; m_tout <= 0; m_txr <= 0; m_mdm <= 0; m_txc_d <= 0; m_idle <= 0;
    end else begin
      bit flush, txc, clr_tx;
      flush = fcr_wr && fcr_rx_reset;
      txc = fifo_mode ? (int'(tx_level) <= 8) : (tx_level == 0);
      clr_tx = thr_wr || (iir_rd && ref_id() == 4'b0010);
      if (err_overrun || err_parity || err_framing || err_break) m_line <= 1;
      else if (lsr_rd) m_line <= 0;
      if (msc_cts || msc_dsr || msc_ri || msc_dcd) m_mdm <= 1;
      else if (msr_rd) m_mdm <= 0;
      if (fifo_mode) m_rxd <= !flush && (rx_level >= rx_trigger);
      else if (rx_push) m_rxd <= 1;
      else if (rbr_rd) m_rxd <= 0;
      if (!fifo_mode || rx_level == 0 || rbr_rd || start_bit || flush) m_tout <= 0;
      else if (m_idle == 40) m_tout <= 1;
      if (rx_push || rbr_rd || start_bit || flush || !fifo_mode) m_idle <= 0;
      else if (bit_tick && m_idle < 40) m_idle <= m_idle + 1;
      m_txc_d <= txc;
      if (clr_tx || !txc) m_txr <= 0;
      else if (!m_txc_d) m_txr <= 1;
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      checks++;
      if (irq_id !== ref_id() || irq !== (ref_id() != 4'b0001)) begin
        errors++;
        $display("FAIL %s model: id=%b irq=%b expected id=%b", phase, irq_id, irq, ref_id());
      end
    end
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic cyc(int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic expect_id(logic [3:0] e, string req);
    checks++;
    if (irq_id !== e || irq !== (e != 4'b0001)) begin
      errors++;
      $display("FAIL %s: id=%b irq=%b expected id=%b", req, irq_id, irq, e);
    end
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin bit_tick = 1; cyc(); end
    bit_tick = 0;
  endtask

  initial begin
    cyc(2);
    expect_id(4'b0001, "R1 in reset");
    rst_n = 1; cyc(2);
    expect_id(4'b0001, "R1 after reset");

    phase = "R3";
    err_parity = 1; cyc(); err_parity = 0; expect_id(4'b0110, "R3 parity");
    cyc(3); expect_id(4'b0110, "R3 held");
    lsr_rd = 1; err_break = 1; cyc(); lsr_rd = 0; err_break = 0; expect_id(4'b0110, "R3 set wins");
    lsr_rd = 1; cyc(); lsr_rd = 0; expect_id(4'b0001, "R3 lsr read");

    phase = "R10";
    msc_ri = 1; cyc(); msc_ri = 0; expect_id(4'b0000, "R10 ring");
    phase = "R2";
    err_overrun = 1; cyc(); err_overrun = 0; expect_id(4'b0110, "R2 line over modem");
    lsr_rd = 1; cyc(); lsr_rd = 0; expect_id(4'b0000, "R2 modem remains");
    phase = "R10";
    msr_rd = 1; cyc(); msr_rd = 0; expect_id(4'b0001, "R10 msr read");

    phase = "R4";
    rx_level = 1; rx_push = 1; cyc(); rx_push = 0; expect_id(4'b0100, "R4 push");
    rx_level = 0; rbr_rd = 1; cyc(); rbr_rd = 0; expect_id(4'b0001, "R4 read");

    phase = "R8";
    tx_level = 0; cyc(); expect_id(4'b0010, "R8 empty");
    phase = "R9";
    iir_rd = 1; cyc(); iir_rd = 0; expect_id(4'b0001, "R9 iir read");
    cyc(2); expect_id(4'b0001, "R8 no re-raise while empty");
    tx_level = 1; cyc(); tx_level = 0; cyc(); expect_id(4'b0010, "R8 re-empty");
    thr_wr = 1; tx_level = 1; cyc(); thr_wr = 0; expect_id(4'b0001, "R9 write");
    tx_level = 0; cyc(); err_framing = 1; cyc(); err_framing = 0;
    iir_rd = 1; cyc(); iir_rd = 0; expect_id(4'b0110, "R9 iir while line");
    lsr_rd = 1; cyc(); lsr_rd = 0; expect_id(4'b0010, "R9 tx kept");
    iir_rd = 1; cyc(); iir_rd = 0; expect_id(4'b0001, "R9 then cleared");

    phase = "R8";
    fifo_mode = 1; tx_level = 16; cyc();
    tx_level = 8; cyc(); expect_id(4'b0010, "R8 half");
    thr_wr = 1; tx_level = 9; cyc(); thr_wr = 0; expect_id(4'b0001, "R9 fifo write");

    phase = "R5";
    rx_trigger = 4; rx_level = 3; rx_push = 1; cyc(); rx_push = 0; expect_id(4'b0001, "R5 below trigger");
    rx_level = 4; rx_push = 1; cyc(); rx_push = 0; expect_id(4'b0100, "R5 at trigger");
    fcr_wr = 1; cyc(); fcr_wr = 0; expect_id(4'b0100, "R5 fcr no reset bit");
    fcr_wr = 1; fcr_rx_reset = 1; cyc(); fcr_wr = 0; fcr_rx_reset = 0; expect_id(4'b0001, "R5 flush");
    cyc(); expect_id(4'b0100, "R5 level still high");
    rx_level = 3; rbr_rd = 1; cyc(); rbr_rd = 0; expect_id(4'b0001, "R5 below after read");

    phase = "R6";
    rx_level = 2; cyc();
    ticks(39); expect_id(4'b0001, "R6 39 ticks");
    ticks(1); expect_id(4'b0001, "R6 40th tick edge");
    cyc(); expect_id(4'b1100, "R6 timeout");
    phase = "R2";
    rx_level = 4; cyc(); expect_id(4'b0100, "R2 data over timeout");
    rx_level = 2; cyc(); expect_id(4'b1100, "R2 timeout remains");

    phase = "R7";
    start_bit = 1; cyc(); start_bit = 0; expect_id(4'b0001, "R7 start bit");
    ticks(40); cyc(); expect_id(4'b1100, "R7 rebuilt");
    rx_level = 1; rbr_rd = 1; cyc(); rbr_rd = 0; expect_id(4'b0001, "R7 fifo read");
    ticks(40); cyc(); expect_id(4'b1100, "R7 rebuilt 2");
    fcr_wr = 1; fcr_rx_reset = 1; cyc(); fcr_wr = 0; fcr_rx_reset = 0; expect_id(4'b0001, "R7 flush");

    phase = "R6";
    fifo_mode = 0; cyc();
    ticks(45); cyc(2); expect_id(4'b0001, "R6 single-buffer no timeout");

    cyc(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule